// File: doc/BRIEF.md
# Vector List Stream Receiver

This block sits behind a byte-oriented serial receiver and turns a stream of packed vector records into writes to a double-buffered list memory for an XY vector display. Each record is three bytes long and carries a 2-bit brightness code and two 11-bit unsigned coordinates. Complete vectors are written into the half of the list that is currently being filled. A record whose brightness code is zero ends the list. When that happens, the filled half is handed over to the drawing side and the block starts filling the other half.

The stream has no framing of its own. A sender that stops in the middle of a record would leave the receiver out of step. The block regains byte alignment from runs of zero bytes, which are long enough only at a frame boundary or after deliberate padding. The memory itself sits outside the block. The block drives a write strobe, an address made of a bank bit above an entry index, and the decoded fields. It also drives a one-cycle completion pulse, the length of the last completed list, the bank that holds that list, and an overflow flag.

Top module: `vec_list_rx`

## Requirements
- R1: A record is three accepted bytes, first byte most significant, forming a 24-bit word. Bits 23:22 are the brightness code (1 transit, 2 normal, 3 bright), bits 21:11 are X and bits 10:0 are Y. A vector with a nonzero code raises `wr_en` in the same cycle as its third byte, with those fields on `wr_bright`, `wr_x` and `wr_y`.
- R2: `wr_addr` is the fill bank in its top bit and the entry index below it. Successive stored vectors of one list take indexes 0, 1, 2 and so on.
- R3: A record with brightness code 0 is never written. If the list holds at least one vector, `frame_done` is high for exactly that cycle. On the next cycle `vec_count` holds the list length, `rd_bank` points at the bank just filled, and filling restarts at index 0 of the other bank.
- R4: A terminating record that arrives while the list is empty gives no `frame_done` pulse, changes no bank and leaves `vec_count` unchanged.
- R5: The fourth consecutive accepted zero byte resets byte alignment and is not part of any record. Further zero bytes are ignored, and the next nonzero byte becomes the first byte of a new record. That fourth zero also completes a non-empty list exactly as in R3.
- R6: With DEPTH entries already stored, further vectors give no `wr_en`, and `overflow` is set from the next cycle on. A list completion returns `overflow` to 0 and reports a count of DEPTH.
- R7: While `rst_n` is low, and right after it is released, `wr_en` and `frame_done` are 0, `vec_count` is 0, `overflow` is 0, `rd_bank` is 1 (filling bank 0), and the next byte is taken as a record's first byte.
- R8: A cycle with `in_valid` low changes neither the byte alignment nor the zero-run state, and it produces no write and no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A byte is offered this cycle |
| in_byte | input | 8 | Offered byte |
| wr_en | output | 1 | Vector write strobe |
| wr_addr | output | $clog2(DEPTH)+1 | Bank bit above entry index |
| wr_x | output | 11 | X coordinate of written vector |
| wr_y | output | 11 | Y coordinate of written vector |
| wr_bright | output | 2 | Brightness code of written vector |
| frame_done | output | 1 | One-cycle pulse when a non-empty list completes |
| vec_count | output | $clog2(DEPTH+1) | Length of the last completed list |
| rd_bank | output | 1 | Bank holding the last completed list |
| overflow | output | 1 | Vectors were dropped from the current list |

## Verification
Directed lists with extreme coordinates and every nonzero brightness code separate field slicing and byte-order faults. The same records with idle gaps between the bytes show whether idle cycles are wrongly counted as bytes. Two kinds of terminator are applied: an all-zero one after a filled list and a nonzero-payload one on an empty list. They separate the pulse, count and bank handover from the empty-list case. An abort in the middle of a record, followed by zero padding, shows whether alignment is recovered on the fourth zero and not earlier, and a list longer than DEPTH exercises dropping and the overflow flag. A long stream of random bytes, about half of them zeros, is then compared cycle by cycle against a behavioural model to reach mixed orderings of partial records, short zero runs and completions.

// File: rtl/vlr_pkg.sv
package vlr_pkg;
  localparam int COORD_W   = 11;
  localparam int BRIGHT_W  = 2;
  localparam int ZRUN_SYNC = 4;

  typedef enum logic [1:0] {
    PH_B0 = 2'd0,
    PH_B1 = 2'd1,
    PH_B2 = 2'd2
  } phase_e;

  typedef struct packed {
    logic [BRIGHT_W-1:0] bright;
    logic [COORD_W-1:0]  x;
    logic [COORD_W-1:0]  y;
  } vec_rec_t;
endpackage

// File: rtl/vlr_byte_align.sv
module vlr_byte_align
  import vlr_pkg::*;
#(
  parameter int SYNC_RUN = ZRUN_SYNC
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     in_valid,
  input  logic [7:0] in_byte,
  output logic     rec_valid,
  output vec_rec_t rec_word,
  output logic     resync
);
  localparam int ZW = $clog2(SYNC_RUN + 1);
  localparam logic [ZW-1:0] ZMAX = ZW'(SYNC_RUN);

  phase_e        phase_q, phase_d;
  logic [7:0]    hi_q, hi_d, mid_q, mid_d;
  logic [ZW-1:0] zrun_q, zrun_d;
  logic          zero_byte;

  always_comb begin
    zero_byte = (in_byte == 8'h00);
    phase_d   = phase_q;
    hi_d      = hi_q;
    mid_d     = mid_q;
    zrun_d    = zrun_q;
    rec_valid = 1'b0;
    resync    = 1'b0;
    rec_word  = {hi_q, mid_q, in_byte};
    if (in_valid) begin
      if (!zero_byte)          zrun_d = '0;
      else if (zrun_q != ZMAX) zrun_d = zrun_q + 1'b1;
      if (zero_byte && zrun_d == ZMAX) begin
        resync  = 1'b1;
        phase_d = PH_B0;
      end else begin
        unique case (phase_q)
          PH_B0: begin hi_d  = in_byte; phase_d = PH_B1; end
          PH_B1: begin mid_d = in_byte; phase_d = PH_B2; end
          default: begin rec_valid = 1'b1; phase_d = PH_B0; end
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_B0;
      hi_q    <= '0;
      mid_q   <= '0;
      zrun_q  <= '0;
    end else if (in_valid) begin
      phase_q <= phase_d;
      hi_q    <= hi_d;
      mid_q   <= mid_d;
      zrun_q  <= zrun_d;
    end
  end

  a_r1_phase_legal: assert property (@(posedge clk) disable iff (!rst_n)
    logic'(phase_q != PH_B0) |-> (phase_q == PH_B1 || phase_q == PH_B2));
  a_r5_run_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    zrun_q <= ZMAX);
  a_r5_realign: assert property (@(posedge clk) disable iff (!rst_n)
    resync |=> (phase_q == PH_B0) && (zrun_q == ZMAX));
  a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(phase_q) && $stable(zrun_q));
endmodule

// File: rtl/vlr_list_writer.sv
module vlr_list_writer
  import vlr_pkg::*;
#(
  parameter int DEPTH = 1024
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         rec_valid,
  input  vec_rec_t                     rec_word,
  input  logic                         resync,
  output logic                         wr_en,
  output logic [$clog2(DEPTH):0]       wr_addr,
  output logic [COORD_W-1:0]           wr_x,
  output logic [COORD_W-1:0]           wr_y,
  output logic [BRIGHT_W-1:0]          wr_bright,
  output logic                         frame_done,
  output logic [$clog2(DEPTH+1)-1:0]   vec_count,
  output logic                         rd_bank,
  output logic                         overflow
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  logic             bank_q, bank_d;
  logic [CNT_W-1:0] fill_q, fill_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             ovf_q, ovf_d;
  logic             is_vec, is_term, has_room, upd_en;

  always_comb begin
    is_vec     = rec_valid && (rec_word.bright != '0);
    is_term    = resync || (rec_valid && (rec_word.bright == '0));
    has_room   = (fill_q < FULL);
    wr_en      = is_vec && has_room;
    frame_done = is_term && (fill_q != '0);
    upd_en     = rec_valid || resync;
    bank_d = bank_q;
    fill_d = fill_q;
    cnt_d  = cnt_q;
    ovf_d  = ovf_q;
    if (frame_done) begin
      bank_d = ~bank_q;
      fill_d = '0;
      cnt_d  = fill_q;
      ovf_d  = 1'b0;
    end else begin
      if (wr_en)               fill_d = fill_q + 1'b1;
      if (is_vec && !has_room) ovf_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_q <= 1'b0;
      fill_q <= '0;
      cnt_q  <= '0;
      ovf_q  <= 1'b0;
    end else if (upd_en) begin
      bank_q <= bank_d;
      fill_q <= fill_d;
      cnt_q  <= cnt_d;
      ovf_q  <= ovf_d;
    end
  end

  assign wr_addr   = {bank_q, fill_q[IDX_W-1:0]};
  assign wr_x      = rec_word.x;
  assign wr_y      = rec_word.y;
  assign wr_bright = rec_word.bright;
  assign vec_count = cnt_q;
  assign rd_bank   = ~bank_q;
  assign overflow  = ovf_q;

  a_r2_index_step: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> fill_q == $past(fill_q) + 1'b1);
  a_r3_handover: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> (rd_bank != $past(rd_bank)) && (fill_q == '0) && (cnt_q == $past(fill_q)));
  a_r4_empty_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (resync && fill_q == '0) |=> $stable(bank_q) && $stable(cnt_q));
  a_r6_set_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_q) |-> $past(fill_q) == FULL);
  a_r6_clear_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !ovf_q);
endmodule

// File: rtl/vec_list_rx.sv
module vec_list_rx
  import vlr_pkg::*;
#(
  parameter int DEPTH = 1024
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  input  logic [7:0]                 in_byte,
  output logic                       wr_en,
  output logic [$clog2(DEPTH):0]     wr_addr,
  output logic [COORD_W-1:0]         wr_x,
  output logic [COORD_W-1:0]         wr_y,
  output logic [BRIGHT_W-1:0]        wr_bright,
  output logic                       frame_done,
  output logic [$clog2(DEPTH+1)-1:0] vec_count,
  output logic                       rd_bank,
  output logic                       overflow
);
  logic     rec_valid, resync;
  vec_rec_t rec_word;

  vlr_byte_align #(.SYNC_RUN(ZRUN_SYNC)) u_align (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
    .rec_valid(rec_valid), .rec_word(rec_word), .resync(resync)
  );

  vlr_list_writer #(.DEPTH(DEPTH)) u_writer (
    .clk(clk), .rst_n(rst_n), .rec_valid(rec_valid), .rec_word(rec_word),
    .resync(resync), .wr_en(wr_en), .wr_addr(wr_addr), .wr_x(wr_x),
    .wr_y(wr_y), .wr_bright(wr_bright), .frame_done(frame_done),
    .vec_count(vec_count), .rd_bank(rd_bank), .overflow(overflow)
  );

  a_r3_no_write_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> !wr_en);
endmodule

// File: tb/tb_vec_list_rx.sv
module tb_vec_list_rx;
  localparam int DEPTH = 4;
  localparam int IDX_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [7:0] in_byte = 8'h00;
  logic wr_en, frame_done, rd_bank, overflow;
  logic [IDX_W:0] wr_addr;
  logic [10:0] wr_x, wr_y;
  logic [1:0] wr_bright;
  logic [CNT_W-1:0] vec_count;

  int checks = 0;
  int fails = 0;
  bit done_flag = 1'b0;
  bit cmp_on = 1'b0;

  always #10 clk = ~clk;

  vec_list_rx #(.DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_x(wr_x), .wr_y(wr_y),
    .wr_bright(wr_bright), .frame_done(frame_done), .vec_count(vec_count),
    .rd_bank(rd_bank), .overflow(overflow)
  );

  // behavioural reference state
  int m_phase, m_b0, m_b1, m_zrun, m_bank, m_idx, m_ovf, m_cnt;
  int e_wr, e_done, e_rec, e_vec, e_resync, e_br, e_x, e_y, e_zn;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model_eval();
    int w;
    w = (m_b0 << 16) | (m_b1 << 8) | int'(in_byte);
    e_br = (w >> 22) & 3;
    e_x  = (w >> 11) & 2047;
    e_y  = w & 2047;
    e_zn = (in_byte == 0) ? ((m_zrun < 4) ? m_zrun + 1 : 4) : 0;
    e_resync = (in_valid && in_byte == 0 && e_zn == 4) ? 1 : 0;
    e_rec  = (in_valid && !e_resync && m_phase == 2) ? 1 : 0;
    e_vec  = (e_rec && e_br != 0) ? 1 : 0;
    e_done = ((e_resync || (e_rec && e_br == 0)) && m_idx > 0) ? 1 : 0;
    e_wr   = (e_vec && m_idx < DEPTH) ? 1 : 0;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_phase = 0; m_b0 = 0; m_b1 = 0; m_zrun = 0;
      m_bank = 0; m_idx = 0; m_ovf = 0; m_cnt = 0;
    end else begin
      model_eval();
      if (in_valid) begin
        m_zrun = e_zn;
        if (e_resync) m_phase = 0;
        else if (m_phase == 0) begin m_b0 = int'(in_byte); m_phase = 1; end
        else if (m_phase == 1) begin m_b1 = int'(in_byte); m_phase = 2; end
        else m_phase = 0;
      end
      if (e_done) begin
        m_cnt = m_idx; m_bank = 1 - m_bank; m_idx = 0; m_ovf = 0;
      end else begin
        if (e_wr) m_idx++;
        else if (e_vec) m_ovf = 1;
      end
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && cmp_on) begin
      model_eval();
      chk(int'(wr_en) == e_wr, "R1 wr_en", int'(wr_en), e_wr);
      chk(int'(frame_done) == e_done, "R3 frame_done", int'(frame_done), e_done);
      chk(int'(rd_bank) == 1 - m_bank, "R3 rd_bank", int'(rd_bank), 1 - m_bank);
      chk(int'(vec_count) == m_cnt, "R3 vec_count", int'(vec_count), m_cnt);
      chk(int'(overflow) == m_ovf, "R6 overflow", int'(overflow), m_ovf);
      if (e_wr != 0) begin
        chk(int'(wr_addr) == m_bank * (1 << IDX_W) + m_idx, "R2 wr_addr",
            int'(wr_addr), m_bank * (1 << IDX_W) + m_idx);
        chk(int'(wr_x) == e_x, "R1 wr_x", int'(wr_x), e_x);
        chk(int'(wr_y) == e_y, "R1 wr_y", int'(wr_y), e_y);
        chk(int'(wr_bright) == e_br, "R1 wr_bright", int'(wr_bright), e_br);
      end
    end
  end

  task automatic send_byte(input logic [7:0] b);
    in_valid = 1'b1;
    in_byte  = b;
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  function automatic logic [23:0] pack(input int br, input int x, input int y);
    return 24'(((br & 3) << 22) | ((x & 2047) << 11) | (y & 2047));
  endfunction

  // send a vector and probe the write port in the third byte's cycle
  task automatic vec_probe(input int br, input int x, input int y, input int gap,
                           input int exp_wr, input int exp_addr, input string tag);
    logic [23:0] w;
    w = pack(br, x, y);
    send_byte(w[23:16]); idle(gap);
    send_byte(w[15:8]);  idle(gap);
    in_valid = 1'b1; in_byte = w[7:0];
    @(negedge clk);
    chk(int'(wr_en) == exp_wr, {tag, " strobe"}, int'(wr_en), exp_wr);
    if (exp_wr != 0) begin
      chk(int'(wr_addr) == exp_addr, {tag, " addr"}, int'(wr_addr), exp_addr);
      chk(int'(wr_x) == x && int'(wr_y) == y && int'(wr_bright) == br,
          {tag, " fields"}, int'({wr_bright, wr_x, wr_y}), int'(w));
    end
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  // last byte of a terminator or zero run, probing the completion pulse
  task automatic last_probe(input logic [7:0] b, input int exp_done, input string tag);
    in_valid = 1'b1; in_byte = b;
    @(negedge clk);
    chk(int'(frame_done) == exp_done, tag, int'(frame_done), exp_done);
    chk(wr_en == 1'b0, {tag, " no write"}, int'(wr_en), 0);
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_flag) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    idle(3);
    @(negedge clk);
    // R7: state held in reset
    chk(wr_en == 1'b0 && frame_done == 1'b0, "R7 strobes in reset", int'({wr_en, frame_done}), 0);
    chk(int'(vec_count) == 0 && overflow == 1'b0, "R7 count/overflow", int'({overflow, vec_count}), 0);
    chk(rd_bank == 1'b1, "R7 rd_bank", int'(rd_bank), 1);
    @(posedge clk); #1;
    rst_n = 1'b1;
    cmp_on = 1'b1;

    // R1/R2: three vectors, extreme fields, back to back
    vec_probe(2, 100, 200, 0, 1, 0, "R1 v0");
    vec_probe(1, 0, 0, 0, 1, 1, "R2 v1");
    // R8: idle gaps between bytes
    vec_probe(3, 2047, 2047, 3, 1, 2, "R8 v2 gapped");
    idle(2);
    // R3: all-zero terminator
    send_byte(8'h00); send_byte(8'h00);
    last_probe(8'h00, 1, "R3 done pulse");
    chk(int'(vec_count) == 3, "R3 count", int'(vec_count), 3);
    chk(rd_bank == 1'b0, "R3 bank swap", int'(rd_bank), 0);

    // R4: terminator with nonzero payload on empty list
    send_byte(8'h01); send_byte(8'h02);
    last_probe(8'h03, 0, "R4 empty no pulse");
    chk(rd_bank == 1'b0 && int'(vec_count) == 3, "R4 unchanged", int'({rd_bank, vec_count}), 3);

    // R5: abort mid-record, then zero padding
    vec_probe(2, 5, 6, 0, 1, 4, "R5 pre-abort");
    send_byte(8'h80); send_byte(8'h12);
    send_byte(8'h00); send_byte(8'h00); send_byte(8'h00);
    last_probe(8'h00, 1, "R5 resync pulse");
    chk(int'(vec_count) == 2, "R5 count", int'(vec_count), 2);
    chk(rd_bank == 1'b1, "R5 bank", int'(rd_bank), 1);
    last_probe(8'h00, 0, "R5 extra zero");
    last_probe(8'h00, 0, "R5 extra zero 2");
    vec_probe(3, 1234, 77, 0, 1, 0, "R5 realigned");

    // R6: list past DEPTH
    vec_probe(2, 1, 1, 0, 1, 1, "R6 v1");
    vec_probe(2, 2, 2, 0, 1, 2, "R6 v2");
    vec_probe(2, 3, 3, 0, 1, 3, "R6 v3");
    vec_probe(1, 4, 4, 0, 0, 0, "R6 dropped");
    chk(overflow == 1'b1, "R6 overflow set", int'(overflow), 1);
    vec_probe(3, 5, 5, 0, 0, 0, "R6 dropped 2");
    send_byte(8'h00); send_byte(8'h00);
    last_probe(8'h00, 1, "R6 done");
    chk(int'(vec_count) == DEPTH, "R6 count", int'(vec_count), DEPTH);
    chk(overflow == 1'b0, "R6 overflow cleared", int'(overflow), 0);

    // mixed random stream, compared every cycle
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = int'($urandom_range(0, 9));
      in_valid = (r != 0);
      in_byte  = (r < 6) ? 8'h00 : 8'($urandom_range(1, 255));
      @(posedge clk); #1;
    end
    in_valid = 1'b0;
    idle(4);

    done_flag = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule